// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block gathers hardware error events into a sticky capture register and decides which of three attention lines each pending error raises. Software reaches five 64-bit registers over a simple register bus: the capture register, a mask, two action registers and a first-error register. The capture and mask registers each have three addresses. One address loads the register outright. A second ANDs the written data into it, so zero bits clear. A third ORs the data in, so one bits set.

Every cycle the `err_in` vector is ORed into the capture register, after any software update in that same cycle. When the first-error register is empty, it takes a one-hot copy of the lowest newly raised, unmasked error bit. That register is handled by a two-state machine. The state is `WOF_EMPTY` or `WOF_HELD`, and the transitions are CAPTURE (EMPTY to HELD on a new unmasked error), CLEAR (HELD to EMPTY on a write with no new error), RECAPTURE (HELD to HELD on a write that coincides with a new error) and HOLD (no change). A write to the first-error register empties it whatever data is written. Each unmasked captured bit drives one attention output, chosen by its pair of action bits.

Top module: `fir_bank`

## Requirements
- R1: A write to byte address 0x00 (index 0) replaces the capture register with the written data.
- R2: A write to index 1 (address 0x08) ANDs the data into the capture register, so zero bits clear.
- R3: A write to index 2 (address 0x10) ORs the data into the capture register.
- R4: The mask register is loaded at index 3, AND-updated at index 4 and OR-updated at index 5.
- R5: Action register 0 (index 6) and action register 1 (index 7) are plain read/write registers.
- R6: Any write to index 8 clears the first-error register to zero, whatever the data, unless a new unmasked error arrives in that same cycle.
- R7: The register index is the byte address shifted right by 3. A write whose address has nonzero low three bits, or whose index is above 8, changes nothing. Such addresses read as zero.
- R8: `err_in` is ORed into the capture register every cycle, after any software write in that cycle, so a same-cycle clearing write never loses an error.
- R9: While the first-error register is zero, it captures the lowest-numbered bit that is set in `err_in`, clear in the capture value after the software update, and clear in the mask after the software update. It holds this one-hot value until it is written.
- R10: Each captured bit whose mask bit is 0 raises exactly one output, selected by {action0, action1}: 00 raises `attn_recov`, 01 raises `attn_chkstop`, and 1x raises `attn_local`.
- R11: All registers are zero after reset. Reading an alias index returns the underlying register, and `reg_rdata` shows the register addressed by `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | ADDR_W (7) | Byte address; bits [ADDR_W-1:3] select the register |
| reg_wdata | input | W (64) | Write data |
| reg_rdata | output | W (64) | Read data of the addressed register |
| err_in | input | W (64) | Hardware error events, one per bit |
| attn_recov | output | 1 | Recoverable attention |
| attn_chkstop | output | 1 | Checkstop attention |
| attn_local | output | 1 | Local attention |

## Verification
A corrupted capture or mask bit shows on the attention outputs right after the clock edge that stores it. It also shows on any read of index 0 to 5 from that point on. A wrong first-error value has no effect on the attention outputs, so it is visible only by reading index 8. For that reason the reference model checks the read data on every cycle against the register currently addressed, and the stimulus includes read cycles at index 8. Mistakes in the AND and OR alias rules, or in the order of the software and hardware updates, show up in the first cycle where a write and an error event touch the same bit.

// File: rtl/fir_pkg.sv
package fir_pkg;
    // register indices (byte address >> 3)
    localparam int IX_CAP     = 0;
    localparam int IX_CAP_AND = 1;
    localparam int IX_CAP_OR  = 2;
    localparam int IX_MSK     = 3;
    localparam int IX_MSK_AND = 4;
    localparam int IX_MSK_OR  = 5;
    localparam int IX_ACT0    = 6;
    localparam int IX_ACT1    = 7;
    localparam int IX_WOF     = 8;

    typedef struct packed {
        logic ld;   // replace
        logic clr;  // AND in
        logic set;  // OR in
    } upd_t;

    typedef enum logic {
        WOF_EMPTY = 1'b0,
        WOF_HELD  = 1'b1
    } wof_state_t;
endpackage

// File: rtl/fir_decode.sv
module fir_decode
    import fir_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output upd_t              cap_op,
    output upd_t              msk_op,
    output logic              act0_we,
    output logic              act1_we,
    output logic              wof_clr,
    output logic              rd_ok,
    output logic [IDX_W-1:0]  rd_idx
);
    logic aligned;

    always_comb begin
        aligned = (addr[2:0] == 3'b000);
        rd_idx  = addr[ADDR_W-1:3];
        rd_ok   = aligned && (rd_idx <= IDX_W'(IX_WOF));
        cap_op  = '0;
        msk_op  = '0;
        act0_we = 1'b0;
        act1_we = 1'b0;
        wof_clr = 1'b0;
        if (wr && aligned) begin
            case (rd_idx)
                IDX_W'(IX_CAP):     cap_op.ld  = 1'b1;
                IDX_W'(IX_CAP_AND): cap_op.clr = 1'b1;
                IDX_W'(IX_CAP_OR):  cap_op.set = 1'b1;
                IDX_W'(IX_MSK):     msk_op.ld  = 1'b1;
                IDX_W'(IX_MSK_AND): msk_op.clr = 1'b1;
                IDX_W'(IX_MSK_OR):  msk_op.set = 1'b1;
                IDX_W'(IX_ACT0):    act0_we    = 1'b1;
                IDX_W'(IX_ACT1):    act1_we    = 1'b1;
                IDX_W'(IX_WOF):     wof_clr    = 1'b1;
                default: ;
            endcase
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_op, msk_op, act0_we, act1_we, wof_clr})); // R7
    AST_MISALIGNED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2:0] != 3'b000) |-> ({cap_op, msk_op, act0_we, act1_we, wof_clr} == '0)); // R7
endmodule

// File: rtl/fir_reg.sv
module fir_reg
    import fir_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  upd_t         op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q,
    output logic [W-1:0] sw_q
);
    // software stage first, hardware OR after it
    always_comb begin
        sw_q = q;
        if (op.ld)       sw_q = wdata;
        else if (op.clr) sw_q = q & wdata;
        else if (op.set) sw_q = q | wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= sw_q | hw_set;
    end

    AST_HW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set))); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == '0 && hw_set == '0) |=> $stable(q)); // R7
endmodule

// File: rtl/fir_wof.sv
module fir_wof
    import fir_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] newbits,
    output logic [W-1:0] wof_q
);
    wof_state_t   state, state_nx;
    logic [W-1:0] wof_nx;
    logic [W-1:0] lowest;

    assign lowest = newbits & (~newbits + W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WOF_EMPTY;
            wof_q <= '0;
        end else begin
            state <= state_nx;
            wof_q <= wof_nx;
        end
    end

    // next state and output value
    always_comb begin
        state_nx = state;
        wof_nx   = wof_q;
        unique case (state)
            WOF_EMPTY: begin
                if (newbits != '0) begin           // CAPTURE
                    state_nx = WOF_HELD;
                    wof_nx   = lowest;
                end
            end
            WOF_HELD: begin
                if (clr && newbits != '0) begin    // RECAPTURE
                    wof_nx = lowest;
                end else if (clr) begin            // CLEAR
                    state_nx = WOF_EMPTY;
                    wof_nx   = '0;
                end
            end
            default: begin
                state_nx = WOF_EMPTY;
                wof_nx   = '0;
            end
        endcase
    end

    AST_WOF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wof_q)); // R9
    AST_WOF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WOF_HELD && !clr) |=> $stable(wof_q)); // R9
    AST_WOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && newbits == '0) |=> (wof_q == '0)); // R6
    AST_WOF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WOF_EMPTY && newbits != '0) |=> (wof_q != '0)); // R9
endmodule

// File: rtl/fir_bank.sv
module fir_bank
    import fir_pkg::*;
#(
    parameter int W      = 64,
    parameter int ADDR_W = 7,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic [W-1:0]      err_in,
    output logic              attn_recov,
    output logic              attn_chkstop,
    output logic              attn_local
);
    upd_t             cap_op, msk_op;
    logic             act0_we, act1_we, wof_clr, rd_ok;
    logic [IDX_W-1:0] rd_idx;
    logic [W-1:0]     cap_q, cap_sw, msk_q, msk_sw, act0_q, act1_q, wof_q;
    logic [W-1:0]     newbits, live;
    logic [W-1:0]     rec_v, chk_v, loc_v;

    fir_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .cap_op(cap_op), .msk_op(msk_op), .act0_we(act0_we), .act1_we(act1_we),
        .wof_clr(wof_clr), .rd_ok(rd_ok), .rd_idx(rd_idx)
    );

    fir_reg #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .op(cap_op), .wdata(reg_wdata),
        .hw_set(err_in), .q(cap_q), .sw_q(cap_sw)
    );

    fir_reg #(.W(W)) u_msk (
        .clk(clk), .rst_n(rst_n), .op(msk_op), .wdata(reg_wdata),
        .hw_set('0), .q(msk_q), .sw_q(msk_sw)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act0_q <= '0;
            act1_q <= '0;
        end else begin
            if (act0_we) act0_q <= reg_wdata;
            if (act1_we) act1_q <= reg_wdata;
        end
    end

    assign newbits = err_in & ~cap_sw & ~msk_sw;

    fir_wof #(.W(W)) u_wof (
        .clk(clk), .rst_n(rst_n), .clr(wof_clr), .newbits(newbits), .wof_q(wof_q)
    );

    // read mux: aliases return the underlying register
    always_comb begin
        reg_rdata = '0;
        if (rd_ok) begin
            case (rd_idx)
                IDX_W'(IX_CAP), IDX_W'(IX_CAP_AND), IDX_W'(IX_CAP_OR): reg_rdata = cap_q;
                IDX_W'(IX_MSK), IDX_W'(IX_MSK_AND), IDX_W'(IX_MSK_OR): reg_rdata = msk_q;
                IDX_W'(IX_ACT0): reg_rdata = act0_q;
                IDX_W'(IX_ACT1): reg_rdata = act1_q;
                IDX_W'(IX_WOF):  reg_rdata = wof_q;
                default:         reg_rdata = '0;
            endcase
        end
    end

    // per-bit attention classification
    assign live = cap_q & ~msk_q;
    for (genvar i = 0; i < W; i++) begin : g_cls
        assign rec_v[i] = live[i] & ~act0_q[i] & ~act1_q[i];
        assign chk_v[i] = live[i] & ~act0_q[i] &  act1_q[i];
        assign loc_v[i] = live[i] &  act0_q[i];
    end

    assign attn_recov   = |rec_v;
    assign attn_chkstop = |chk_v;
    assign attn_local   = |loc_v;

    AST_MASK_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (&msk_q) |-> !(attn_recov || attn_chkstop || attn_local)); // R10
    AST_NO_ATTN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q == '0) |-> !(attn_recov || attn_chkstop || attn_local)); // R10
    AST_CLEAR_WINS_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata == '0 && err_in == '0)
        |=> (cap_q == '0)); // R1
endmodule

// File: tb/test_fir_bank.sv
module test_fir_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [63:0] err_in = '0;
    logic        attn_recov, attn_chkstop, attn_local;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    logic [63:0] m_cap = '0, m_msk = '0, m_a0 = '0, m_a1 = '0, m_wof = '0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;

    fir_bank i_fir_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_in(err_in),
        .attn_recov(attn_recov), .attn_chkstop(attn_chkstop), .attn_local(attn_local)
    );

    function automatic logic [63:0] mread(input logic [6:0] a);
        if (a[2:0] != 3'b000) return '0;
        case (a[6:3])
            4'd0, 4'd1, 4'd2: return m_cap;
            4'd3, 4'd4, 4'd5: return m_msk;
            4'd6: return m_a0;
            4'd7: return m_a1;
            4'd8: return m_wof;
            default: return '0;
        endcase
    endfunction

    function automatic logic [2:0] mattn();
        logic [2:0] r = '0; // {local, chkstop, recov}
        for (int i = 0; i < 64; i++) begin
            if (m_cap[i] && !m_msk[i]) begin
                if (m_a0[i])      r[2] = 1'b1;
                else if (m_a1[i]) r[1] = 1'b1;
                else              r[0] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic mupdate(input logic w, input logic [6:0] a, input logic [63:0] d,
                           input logic [63:0] e);
        logic [63:0] c = m_cap, k = m_msk, nb;
        bit clr = 0;
        if (w && a[2:0] == 3'b000) begin
            case (a[6:3])
                4'd0: c = d;
                4'd1: c = c & d;
                4'd2: c = c | d;
                4'd3: k = d;
                4'd4: k = k & d;
                4'd5: k = k | d;
                4'd6: m_a0 = d;
                4'd7: m_a1 = d;
                4'd8: clr = 1;
                default: ;
            endcase
        end
        if (clr) m_wof = '0;
        nb = e & ~c & ~k;
        if (m_wof == '0) begin
            for (int i = 0; i < 64; i++) begin
                if (nb[i] && m_wof == '0) m_wof = 64'd1 << i;
            end
        end
        m_cap = c | e;
        m_msk = k;
    endtask

    task automatic step(input logic w, input logic [6:0] a, input logic [63:0] d,
                        input logic [63:0] e, input string tag);
        logic [2:0] ea;
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; err_in = e;
        #1;
        total++;
        if (reg_rdata !== mread(a)) begin
            bad++;
            $display("FAIL %s rdata addr=%h got=%h exp=%h", tag, a, reg_rdata, mread(a));
        end
        ea = mattn();
        total++;
        if ({attn_local, attn_chkstop, attn_recov} !== ea) begin
            bad++;
            $display("FAIL R10 attention got=%b exp=%b", {attn_local, attn_chkstop, attn_recov}, ea);
        end
        @(posedge clk);
        if (rst_n) mupdate(w, a, d, e);
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        step(1'b0, a, 64'hDEAD_BEEF_0000_0000, '0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state, every index
        for (int i = 0; i < 9; i++) rd(7'(i * 8), "R11");
        // R1 direct load, R11 alias reads
        step(1, 7'h00, 64'h0000_0000_0000_00F0, '0, "R1");
        rd(7'h00, "R1"); rd(7'h08, "R11"); rd(7'h10, "R11");
        // R2 AND alias
        step(1, 7'h08, 64'h0000_0000_0000_0030, '0, "R2");
        rd(7'h00, "R2");
        // R3 OR alias
        step(1, 7'h10, 64'h8000_0000_0000_000F, '0, "R3");
        rd(7'h00, "R3");
        // R4 mask paths
        step(1, 7'h18, 64'hFFFF_0000_0000_FFFF, '0, "R4");
        rd(7'h18, "R4");
        step(1, 7'h20, 64'h0F0F_0000_0000_00FF, '0, "R4");
        rd(7'h28, "R4");
        step(1, 7'h28, 64'h0000_0001_0000_0000, '0, "R4");
        rd(7'h20, "R4");
        step(1, 7'h18, '0, '0, "R4");
        // R5 action registers, R10 classes
        step(1, 7'h30, 64'h0000_0000_0000_000C, '0, "R5");
        rd(7'h30, "R5");
        step(1, 7'h38, 64'h0000_0000_0000_0003, '0, "R5");
        rd(7'h38, "R10");
        step(1, 7'h18, 64'h0000_0000_0000_000F, '0, "R10");
        rd(7'h00, "R10");
        step(1, 7'h18, '0, '0, "R10");
        // R7 misaligned and unmapped accesses
        step(1, 7'h01, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R7");
        rd(7'h00, "R7"); rd(7'h31, "R7");
        step(1, 7'h60, 64'h1234, '0, "R7");
        rd(7'h60, "R7"); rd(7'h48, "R7");
        for (int i = 0; i < 8; i++) rd(7'(i * 8), "R7");
        // R9 first-error capture
        step(1, 7'h00, '0, '0, "R9");
        step(0, 7'h40, '0, 64'h0000_0000_0000_0A00, "R9");
        rd(7'h40, "R9");
        step(0, 7'h40, '0, 64'h0000_0000_0000_0100, "R9");
        rd(7'h40, "R9");
        // R6 clear regardless of data
        step(1, 7'h40, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R6");
        rd(7'h40, "R6");
        // masked new error not captured
        step(1, 7'h18, 64'h0000_0000_0001_0000, '0, "R9");
        step(0, 7'h40, '0, 64'h0000_0000_0001_0000, "R9");
        rd(7'h40, "R9");
        step(0, 7'h40, '0, 64'h0000_0000_0010_0000, "R9");
        // R6 clear coinciding with new error -> recapture
        step(1, 7'h40, '0, 64'h0000_0000_0400_0000, "R6");
        rd(7'h40, "R6");
        // R8 software clear and error in same cycle
        step(1, 7'h00, '0, 64'h0000_4000_0000_0000, "R8");
        rd(7'h00, "R8");
        step(1, 7'h08, '0, 64'h0000_0000_0000_0001, "R8");
        rd(7'h00, "R8");
        // mixed pseudo-random traffic
        for (int n = 0; n < 600; n++) begin
            logic [63:0] e;
            logic [6:0]  a;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
            a = (rng[3:0] < 4'd10) ? {rng[3:0], 3'b000} : {rng[7:4], rng[10:8]};
            e = (rng[15:12] == 4'd0) ? (64'd1 << rng[21:16]) : 64'd0;
            step(rng[11], a, {rng[31:0], rng[63:32]} & {64{rng[40]}} | rng, e, "R8");
        end
        for (int i = 0; i < 9; i++) rd(7'(i * 8), "R11");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule